// File: doc/BRIEF.md
# Overlapped FFT Frame Buffer Scheduler

This block sits between a complex (I/Q) sample stream and an FFT engine. It builds FFT input frames whose sampling windows overlap. The input arrives at four times the per-frame sample rate. Consecutive input samples are dealt in turn to four interleaved frames, one per phase. Each frame therefore holds every fourth sample and spans four times its own length in input time. The four phases are staggered by a quarter of a frame, so a frame completes once per quarter window and the windows overlap by 75%.

Before a sample is stored, it is scaled by a window coefficient. The coefficient is computed from the point's position within its frame. The product is then rounded back to the sample width. Each new frame takes the next of eight buffers in rotation from a two-port memory, and a completed frame is announced with a one-cycle pulse and its buffer index. The FFT engine reads the stored points through an independent read port while filling continues in other buffers. A completed buffer is not reused for another four frame periods.

Top module: `ovl_frame_sched`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, `frm_rdy` is 0 and `frm_buf` is 0. Reset clears the sample counters, buffer allocation and frame history, so numbering restarts at sample 0.
- R2: Counting accepted samples from n = 0 after reset, sample n belongs to phase p = n mod 4.
- R3: Sample n is stored at point k = (floor(n/4) − 64·p) mod 256 of its phase's current frame. A frame of phase p starts when k = 0.
- R4: The window coefficient is the unsigned 16-bit fraction w(k) = (2·min(k, 255−k) + 1)·256, giving a value of w/65536.
- R5: Each stored component equals floor((s·w + 32768) / 65536) for the 16-bit signed input s, saturated to [−32768, 32767].
- R6: A frame completes on its sample with k = 255. In the next cycle `frm_rdy` is 1 for exactly one cycle.
- R7: Frames that started before reset released, or that never reached k = 0, are never announced. After reset the first pulse follows sample 1020, and later pulses follow samples 1277, 1534, 1791, 2044 and so on.
- R8: The index on `frm_buf` is 0 for the first announced frame and increases by 1 modulo 8 with each pulse after that.
- R9: A cycle with `in_valid` low changes no counter and writes nothing, and the next cycle has no pulse.
- R10: `{rd_i, rd_q}` shows the point addressed by `rd_buf`/`rd_pt` one cycle after the address. An announced buffer keeps its contents at least until the following frame has been announced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| frm_rdy | output | 1 | One-cycle frame-complete pulse |
| frm_buf | output | 3 | Buffer index of the completed frame |
| rd_buf | input | 3 | Read buffer select |
| rd_pt | input | 8 | Read point select |
| rd_i | output | 16 | Stored in-phase value, registered |
| rd_q | output | 16 | Stored quadrature value, registered |

## Verification
The bound checker watches four things on every cycle: that the completion pulse lasts one cycle, that an idle cycle is never followed by a pulse, that no pulse can appear before 1021 samples have been accepted, and that the buffer index starts at zero and steps by one. Only the bench scenarios can show that each point lands in the right buffer and position with the right windowed, rounded value. This covers extreme input codes and both edges of the window fold. The same applies to the exact sample numbers of the staggered completions, to the clearing of partial history by a mid-stream reset, and to an announced buffer surviving the next frame.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int OFS_DW   = 16;  // sample component width
  localparam int OFS_CW   = 16;  // window coefficient width (unsigned fraction)
  localparam int OFS_PTS  = 256; // points per frame
  localparam int OFS_PH   = 4;   // interleaved phases
  localparam int OFS_NBUF = 8;   // frame buffers in rotation
endpackage

// File: rtl/ofs_seq.sv
module ofs_seq #(
  parameter int PTS  = ofs_pkg::OFS_PTS,
  parameter int PH   = ofs_pkg::OFS_PH,
  parameter int NBUF = ofs_pkg::OFS_NBUF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     wr_en,
  output logic [$clog2(NBUF)-1:0]  wr_buf,
  output logic [$clog2(PTS)-1:0]   wr_pt,
  output logic                     frm_rdy,
  output logic [$clog2(NBUF)-1:0]  frm_buf
);
  localparam int PW    = $clog2(PTS);
  localparam int HW    = $clog2(PH);
  localparam int BW    = $clog2(NBUF);
  localparam int SHIFT = PW - HW;  // stagger of one phase = PTS/PH points

  logic [HW-1:0] ph_q, ph_d;
  logic [PW-1:0] qc_q, qc_d;
  logic [BW-1:0] alloc_q, alloc_d;
  logic [BW-1:0] pbuf_q [PH];
  logic [BW-1:0] pbuf_d [PH];
  logic [PH-1:0] live_q, live_d;
  logic          rdy_q, rdy_d;
  logic [BW-1:0] rbuf_q, rbuf_d;

  logic          adv_en;
  logic [PW-1:0] stag_off;
  logic [PW-1:0] pt;
  logic          start, last, fire;
  logic [BW-1:0] cur_buf;

  // Point position of the current sample inside its phase's frame
  always_comb begin
    stag_off = PW'(ph_q) << SHIFT;
    pt       = qc_q - stag_off;
    start    = (pt == '0);
    last     = (pt == PW'(PTS - 1));
    cur_buf  = start ? alloc_q : pbuf_q[ph_q];
    adv_en   = in_valid;
    fire     = in_valid && last && live_q[ph_q];
    wr_en    = in_valid && (start || live_q[ph_q]);
  end

  // Next-state logic
  always_comb begin
    ph_d    = ph_q + 1'b1;
    qc_d    = (ph_q == HW'(PH - 1)) ? qc_q + 1'b1 : qc_q;
    alloc_d = start ? alloc_q + 1'b1 : alloc_q;
    pbuf_d  = pbuf_q;
    live_d  = live_q;
    if (start) begin
      pbuf_d[ph_q] = alloc_q;
      live_d[ph_q] = 1'b1;
    end
    rdy_d  = fire;
    rbuf_d = fire ? cur_buf : rbuf_q;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= '0;
      qc_q    <= '0;
      alloc_q <= '0;
      live_q  <= '0;
      for (int j = 0; j < PH; j++) pbuf_q[j] <= '0;
      rdy_q   <= 1'b0;
      rbuf_q  <= '0;
    end else begin
      if (adv_en) begin
        ph_q    <= ph_d;
        qc_q    <= qc_d;
        alloc_q <= alloc_d;
        pbuf_q  <= pbuf_d;
        live_q  <= live_d;
      end
      rdy_q  <= rdy_d;
      rbuf_q <= rbuf_d;
    end
  end

  assign wr_buf  = cur_buf;
  assign wr_pt   = pt;
  assign frm_rdy = rdy_q;
  assign frm_buf = rbuf_q;
endmodule

// File: rtl/ofs_window.sv
module ofs_window #(
  parameter int DW  = ofs_pkg::OFS_DW,
  parameter int CW  = ofs_pkg::OFS_CW,
  parameter int PTS = ofs_pkg::OFS_PTS
) (
  input  logic [$clog2(PTS)-1:0] pt,
  input  logic [DW-1:0]          in_i,
  input  logic [DW-1:0]          in_q,
  output logic [DW-1:0]          out_i,
  output logic [DW-1:0]          out_q
);
  localparam int PW  = $clog2(PTS);
  localparam int PRW = DW + CW + 1;
  localparam logic signed [PRW-1:0] HALF = PRW'(1) << (CW - 1);
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

  logic [PW-1:0] fold;
  logic [CW-1:0] coef;

  // Triangular window folded about the frame centre: odd steps scaled to CW bits
  always_comb begin
    fold = pt[PW-1] ? ~pt : pt;
    coef = CW'({fold[PW-2:0], 1'b1}) << (CW - PW);
  end

  logic [DW-1:0] lane_in  [2];
  logic [DW-1:0] lane_out [2];
  assign lane_in[0] = in_i;
  assign lane_in[1] = in_q;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [PRW-1:0] prod, rnd;
    logic signed [DW:0]    sh;
    always_comb begin
      prod = $signed(lane_in[g]) * $signed({1'b0, coef});
      rnd  = prod + HALF;
      sh   = rnd[PRW-1:CW];
      if (sh[DW] != sh[DW-1]) lane_out[g] = sh[DW] ? NEG_MIN : POS_MAX;
      else                    lane_out[g] = sh[DW-1:0];
    end
  end

  assign out_i = lane_out[0];
  assign out_q = lane_out[1];
endmodule

// File: rtl/ofs_store.sv
module ofs_store #(
  parameter int DW   = ofs_pkg::OFS_DW,
  parameter int PTS  = ofs_pkg::OFS_PTS,
  parameter int NBUF = ofs_pkg::OFS_NBUF
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [$clog2(NBUF)-1:0] wr_buf,
  input  logic [$clog2(PTS)-1:0]  wr_pt,
  input  logic [2*DW-1:0]         wr_word,
  input  logic [$clog2(NBUF)-1:0] rd_buf,
  input  logic [$clog2(PTS)-1:0]  rd_pt,
  output logic [2*DW-1:0]         rd_word
);
  localparam int DEPTH = NBUF * PTS;

  logic [2*DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_buf, wr_pt}] <= wr_word;
  end

  always_ff @(posedge clk) begin
    rd_word <= mem[{rd_buf, rd_pt}];
  end
endmodule

// File: rtl/ovl_frame_sched.sv
module ovl_frame_sched #(
  parameter int DW   = ofs_pkg::OFS_DW,
  parameter int CW   = ofs_pkg::OFS_CW,
  parameter int PTS  = ofs_pkg::OFS_PTS,
  parameter int PH   = ofs_pkg::OFS_PH,
  parameter int NBUF = ofs_pkg::OFS_NBUF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [DW-1:0]           in_i,
  input  logic [DW-1:0]           in_q,
  output logic                    frm_rdy,
  output logic [$clog2(NBUF)-1:0] frm_buf,
  input  logic [$clog2(NBUF)-1:0] rd_buf,
  input  logic [$clog2(PTS)-1:0]  rd_pt,
  output logic [DW-1:0]           rd_i,
  output logic [DW-1:0]           rd_q
);
  localparam int PW = $clog2(PTS);
  localparam int BW = $clog2(NBUF);

  logic          wr_en;
  logic [BW-1:0] wr_buf;
  logic [PW-1:0] wr_pt;
  logic [DW-1:0] win_i, win_q;
  logic [2*DW-1:0] rd_word;

  ofs_seq #(.PTS(PTS), .PH(PH), .NBUF(NBUF)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .wr_en    (wr_en),
    .wr_buf   (wr_buf),
    .wr_pt    (wr_pt),
    .frm_rdy  (frm_rdy),
    .frm_buf  (frm_buf)
  );

  ofs_window #(.DW(DW), .CW(CW), .PTS(PTS)) win_i_u (
    .pt    (wr_pt),
    .in_i  (in_i),
    .in_q  (in_q),
    .out_i (win_i),
    .out_q (win_q)
  );

  ofs_store #(.DW(DW), .PTS(PTS), .NBUF(NBUF)) store_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_buf  (wr_buf),
    .wr_pt   (wr_pt),
    .wr_word ({win_i, win_q}),
    .rd_buf  (rd_buf),
    .rd_pt   (rd_pt),
    .rd_word (rd_word)
  );

  assign rd_i = rd_word[2*DW-1:DW];
  assign rd_q = rd_word[DW-1:0];
endmodule

// File: rtl/ofs_chk.sv
module ofs_chk #(
  parameter int PTS  = ofs_pkg::OFS_PTS,
  parameter int PH   = ofs_pkg::OFS_PH,
  parameter int NBUF = ofs_pkg::OFS_NBUF
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    frm_rdy,
  input logic [$clog2(NBUF)-1:0] frm_buf
);
  localparam int BW   = $clog2(NBUF);
  localparam int SPAN = PTS * PH;
  localparam int AW   = $clog2(SPAN) + 1;

  logic [AW-1:0] acc_q;
  logic          seen_q;
  logic [BW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      seen_q <= 1'b0;
      last_q <= '0;
    end else begin
      if (in_valid && acc_q != AW'(SPAN)) acc_q <= acc_q + 1'b1;
      if (frm_rdy) begin
        seen_q <= 1'b1;
        last_q <= frm_buf;
      end
    end
  end

  // R6
  rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_rdy |=> !frm_rdy);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !frm_rdy);

  // R7
  warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_rdy |-> (acc_q >= AW'(SPAN - PH + 1)));

  // R8
  buf_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_rdy && !seen_q) |-> (frm_buf == '0));

  // R8
  buf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_rdy && seen_q) |-> (frm_buf == BW'(last_q + 1'b1)));
endmodule

bind ovl_frame_sched ofs_chk #(.PTS(PTS), .PH(PH), .NBUF(NBUF)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .frm_rdy  (frm_rdy),
  .frm_buf  (frm_buf)
);

// File: tb/ovl_frame_sched_tb_top.sv
module ovl_frame_sched_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_i, in_q;
  logic        frm_rdy;
  logic [2:0]  frm_buf;
  logic [2:0]  rd_buf;
  logic [7:0]  rd_pt;
  logic [15:0] rd_i, rd_q;

  int n_cmp;
  int n_bad;

  ovl_frame_sched dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .frm_rdy(frm_rdy), .frm_buf(frm_buf), .rd_buf(rd_buf), .rd_pt(rd_pt),
    .rd_i(rd_i), .rd_q(rd_q)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int gen_i(int n);
    if (n % 97 == 0) return -32768;
    if (n % 89 == 0) return 32767;
    return ((n * 7919 + 13) % 65536) - 32768;
  endfunction

  function automatic int gen_q(int n);
    if (n % 101 == 5) return -32768;
    if (n % 83 == 1)  return 32767;
    return ((n * 104729 + 7) % 65536) - 32768;
  endfunction

  // R4 and R5 computed from their formulas
  function automatic int win_val(int s, int k);
    int m;
    longint w, prod, r;
    m = (k < 128) ? k : 255 - k;
    w = longint'(2 * m + 1) * 256;
    prod = longint'(s) * w + 32768;
    r = prod >>> 16;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  // R2 and R3 point position of sample n
  function automatic int pos_of(int n);
    int p, q;
    p = n % 4;
    q = n / 4;
    return (((q - 64 * p) % 256) + 256) % 256;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(int n, bit exp_fire, int exp_idx);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = 16'(gen_i(n));
    in_q = 16'(gen_q(n));
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 R7 ready after sample", int'(frm_rdy), int'(exp_fire));
    if (exp_fire) check("R8 buffer index", int'(frm_buf), exp_idx);
    if (n % 7 == 3) begin
      @(negedge clk);
      check("R9 idle cycle no ready", int'(frm_rdy), 0);
    end
  endtask

  task automatic read_buf(int b, int nc, string req);
    int p, qs, n;
    p  = nc % 4;
    qs = nc / 4 - 255;
    for (int k = 0; k < 256; k++) begin
      rd_buf = 3'(b);
      rd_pt  = 8'(k);
      @(negedge clk);
      n = 4 * (qs + k) + p;
      check(req, int'($signed(rd_i)), win_val(gen_i(n), k));
      check(req, int'($signed(rd_q)), win_val(gen_q(n), k));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int exp_idx, prev_idx, prev_nc, fires;
    bit f;
    n_cmp = 0;
    n_bad = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_i = '0;
    in_q = '0;
    rd_buf = '0;
    rd_pt = '0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(frm_rdy), 0);
    check("R1 index in reset", int'(frm_buf), 0);
    rst_n = 1'b1;

    // Partial history, then a mid-stream reset
    for (int n = 0; n < 600; n++) send(n + 333, 1'b0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", int'(frm_rdy), 0);
    check("R1 index after reset", int'(frm_buf), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after release", int'(frm_rdy), 0);

    exp_idx = 0;
    prev_idx = 0;
    prev_nc = -1;
    fires = 0;
    for (int n = 0; n < 3100; n++) begin
      f = (pos_of(n) == 255) && (n >= 1020);
      send(n, f, exp_idx);
      if (f) begin
        read_buf(exp_idx, n, "R2 R3 R4 R5 stored point");
        if (prev_nc >= 0) read_buf(prev_idx, prev_nc, "R10 previous buffer held");
        prev_idx = exp_idx;
        prev_nc = n;
        exp_idx = (exp_idx + 1) % 8;
        fires++;
      end
    end
    check("R7 R8 frames announced", fires, 9);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule